// File: doc/BRIEF.md
# Host Bridge Window Translation Registers

This block holds the control registers of a PCI host bridge and turns local window offsets into PCI addresses. Software reaches eight 32-bit registers through a simple register port: three window map registers that steer the memory windows, an identity register, a flags register and three secondary map registers. Any agent that is about to issue a PCI access presents a window index and an offset on the translation port. In the same cycle it gets back the PCI address, or an error flag when the offset does not fit the window.

Three memory windows and one fixed I/O window are translated. The board variant is a build parameter. It sets the window sizes and how a map register is read. In the nibble variant, the low four map bits become PCI address bits 31..28. In the masked variant, the map register keeps only the bits above the window size. The I/O window always starts at PCI I/O address 0.

Top module: `pcib_bridge_xlate`

## Requirements
- R1: After a synchronous active-low reset, all eight registers read as zero.
- R2: The registers decode at byte offsets 0x00, 0x04, 0x08 (map 0..2), 0x0C (identity), 0x10 (flags) and 0x14, 0x18, 0x1C (secondary map 0..2). Each holds the last full-width value written to it.
- R3: Only full-width accesses take effect (byte enables 4'hF). A write with any other enable value changes no register, and a read with any other enable value returns 0.
- R4: Offsets at 0x20 or above, and offsets with address bits [1:0] non-zero, are unmapped. Reads there return 0 and writes there change no register.
- R5: With VARIANT=0, a valid memory-window translation returns {map[3:0], offset[27:0]}.
- R6: With VARIANT=1, a valid memory-window translation returns (map AND NOT(size-1)) OR offset.
- R7: xl_win selects memory windows 0, 1 and 2 with codes 0, 1 and 2, and the I/O window with code 3. The memory window sizes are 0x0C000000, 0x10000000 and 0x10000000 for VARIANT=0, and 0x01000000, 0x04000000 and 0x08000000 for VARIANT=1.
- R8: The I/O window spans 0x100000 bytes, and a valid I/O translation returns the offset unchanged (base 0).
- R9: An offset at or beyond the selected window size sets xl_err to 1 and returns address 0. Otherwise xl_err is 0.
- R10: A map register write changes translations from the cycle after the write edge. During the write cycle the previous map value still applies.
- R11: The identity, flags and secondary map registers have no effect on any translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xl_win | input | 2 | Window select: 0..2 memory, 3 I/O |
| xl_offset | input | 32 | Offset within the selected window |
| xl_addr | output | 32 | Translated PCI address, 0 on error |
| xl_err | output | 1 | Offset outside the selected window |

## Verification
The bench builds two instances that share every input: one with VARIANT=0 and one with VARIANT=1. Each write and translation is therefore checked under both map interpretations and both size tables. With both instances side by side, the random offsets hit the window edges, which differ between variants, and the mask boundaries of the masked variant. Directed cases cover the map update on the write edge, partial-enable and unmapped accesses, and writes to the non-map registers while translating.

// File: rtl/pcib_pkg.sv
// Shared constants and helpers for the bridge window translation block.
// Assumes three memory windows and eight registers on a 32-bit data path.
package pcib_pkg;
    localparam int NUM_MWIN = 3;
    localparam int NUM_REGS = 8;
    localparam logic [31:0] IO_WIN_SIZE = 32'h0010_0000;

    // Register index equals byte offset divided by four.
    typedef enum logic [2:0] {
        RIX_MAP0  = 3'd0,
        RIX_MAP1  = 3'd1,
        RIX_MAP2  = 3'd2,
        RIX_IDENT = 3'd3,
        RIX_FLAGS = 3'd4,
        RIX_SEC0  = 3'd5,
        RIX_SEC1  = 3'd6,
        RIX_SEC2  = 3'd7
    } reg_ix_e;

    // Size of memory window idx for a given board variant.
    function automatic logic [31:0] mwin_size(input int variant, input int idx);
        if (variant == 0) begin
            return (idx == 0) ? 32'h0C00_0000 : 32'h1000_0000;
        end
        case (idx)
            0:       return 32'h0100_0000;
            1:       return 32'h0400_0000;
            default: return 32'h0800_0000;
        endcase
    endfunction
endpackage

// File: rtl/pcib_regbank.sv
// Register storage and decode for the bridge control registers.
// Assumes word-aligned offsets and full-width enables; anything else is ignored.
// Reads are combinational; writes land on the clock edge.
module pcib_regbank
    import pcib_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W/8-1:0]              be,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    output logic [NUM_MWIN-1:0][DATA_W-1:0]  map_o
);
    localparam int IX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              full;
    logic              hit;
    logic [IX_W-1:0]   ix;

    // Decode: aligned offset inside the register range with all lanes enabled.
    always_comb begin
        full = &be;
        hit  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS));
        ix   = addr[IX_W+1:2];
    end

    // Storage: clear on reset, load on a valid full-width write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (we && full && hit) begin
            regs_q[ix] <= wdata;
        end
    end

    // Read mux: zero for unmapped or partial accesses.
    always_comb begin
        rdata = (full && hit) ? regs_q[ix] : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_MWIN; g++) begin : g_map
            assign map_o[g] = regs_q[g];
        end
        for (g = 0; g < NUM_REGS; g++) begin : g_hold
            AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!(we && full && hit && (ix == IX_W'(g)))) |=> (regs_q[g] == $past(regs_q[g])))
                else $error("register %0d changed without a valid write", g); // R3
        end
    endgenerate

    AST_MAP0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && full && hit && (ix == IX_W'(RIX_MAP0))) |=> (map_o[0] == $past(wdata)))
        else $error("map0 did not take written value"); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || !full) |-> (rdata == '0))
        else $error("unmapped or partial read returned data"); // R4
endmodule

// File: rtl/pcib_win_unit.sv
// Translation for one memory window.
// Assumes the window size is a power-of-two multiple boundary for the masked
// variant; VARIANT=0 takes the top nibble from the map, VARIANT=1 masks the map.
module pcib_win_unit
    import pcib_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int IDX     = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] map,
    input  logic [31:0] offset,
    output logic [31:0] addr,
    output logic        err
);
    localparam logic [31:0] SIZE = mwin_size(VARIANT, IDX);
    localparam logic [31:0] MASK = ~(SIZE - 32'd1);

    logic [31:0] addr_nib;
    logic [31:0] addr_msk;

    // Form both candidate addresses, then pick by variant and range.
    always_comb begin
        addr_nib = {map[3:0], offset[27:0]};
        addr_msk = (map & MASK) | offset;
        err      = (offset >= SIZE);
        addr     = err ? 32'd0 : ((VARIANT == 0) ? addr_nib : addr_msk);
    end

    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && VARIANT == 0) |-> (addr[27:0] == offset[27:0]))
        else $error("offset bits lost in window %0d", IDX); // R5

    AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (addr == 32'd0))
        else $error("error with non-zero address in window %0d", IDX); // R9
endmodule

// File: rtl/pcib_bridge_xlate.sv
// Top of the bridge register bank and window translator.
// Assumes translation requests are combinational lookups against the
// registered map values; a map write is seen from the following cycle.
module pcib_bridge_xlate
    import pcib_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  xl_win,
    input  logic [31:0] xl_offset,
    output logic [31:0] xl_addr,
    output logic        xl_err
);
    logic [NUM_MWIN-1:0][31:0] map_w;
    logic [NUM_MWIN-1:0][31:0] maddr_w;
    logic [NUM_MWIN-1:0]       merr_w;
    logic                      io_err;

    pcib_regbank #(.ADDR_W(8), .DATA_W(32)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .map_o (map_w)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_MWIN; g++) begin : g_win
            pcib_win_unit #(.VARIANT(VARIANT), .IDX(g)) u_win (
                .clk    (clk),
                .rst_n  (rst_n),
                .map    (map_w[g]),
                .offset (xl_offset),
                .addr   (maddr_w[g]),
                .err    (merr_w[g])
            );
        end
    endgenerate

    // Output select: memory windows by index, code 3 is the fixed I/O window.
    always_comb begin
        io_err = (xl_offset >= IO_WIN_SIZE);
        if (xl_win == 2'd3) begin
            xl_err  = io_err;
            xl_addr = io_err ? 32'd0 : xl_offset;
        end else begin
            xl_err  = merr_w[xl_win];
            xl_addr = maddr_w[xl_win];
        end
    end

    AST_IO_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_win == 2'd3 && !xl_err) |-> (xl_addr == xl_offset))
        else $error("I/O window did not pass offset"); // R8

    AST_IO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_win == 2'd3) |-> (xl_err == (xl_offset >= 32'h0010_0000)))
        else $error("I/O window range flag wrong"); // R9
endmodule

// File: tb/pcib_bridge_xlate_tb.sv
module pcib_bridge_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  xl_win = '0;
    logic [31:0] xl_offset = '0;
    logic [31:0] rd_a, rd_b, xa_a, xa_b;
    logic        xe_a, xe_b;

    int checks = 0;
    int failures = 0;
    logic [31:0] mdl [8];

    always #4 clk = ~clk;

    pcib_bridge_xlate #(.VARIANT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_a),
        .xl_win(xl_win), .xl_offset(xl_offset), .xl_addr(xa_a), .xl_err(xe_a));

    pcib_bridge_xlate #(.VARIANT(1)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_b),
        .xl_win(xl_win), .xl_offset(xl_offset), .xl_addr(xa_b), .xl_err(xe_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Window size from R7 and R8.
    function automatic logic [31:0] wsize(input int v, input int w);
        if (w == 3) return 32'h0010_0000;
        if (v == 0) return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
        if (w == 0) return 32'h0100_0000;
        if (w == 1) return 32'h0400_0000;
        return 32'h0800_0000;
    endfunction

    // Expected {err, addr} from R5, R6, R8 and R9.
    function automatic logic [32:0] exp_x(input int v, input int w, input logic [31:0] off);
        logic [31:0] sz;
        logic [31:0] m;
        sz = wsize(v, w);
        if (off >= sz) return {1'b1, 32'd0};
        if (w == 3) return {1'b0, off};
        m = mdl[w];
        if (v == 0) return {1'b0, m[3:0], off[27:0]};
        return {1'b0, (m & ~(sz - 32'd1)) | off};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 4'hF;
        if (be == 4'hF && a[1:0] == 2'b00 && a < 8'h20) mdl[a[4:2]] = d;
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input logic [3:0] be,
                           input logic [31:0] exp);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a; reg_be = be;
        #1;
        chk({tag, " var0"}, rd_a, exp);
        chk({tag, " var1"}, rd_b, exp);
        reg_be = 4'hF;
    endtask

    task automatic do_xlate(input string tag, input int w, input logic [31:0] off);
        logic [32:0] ea, eb;
        @(negedge clk);
        xl_win = 2'(w); xl_offset = off;
        #1;
        ea = exp_x(0, w, off);
        eb = exp_x(1, w, off);
        chk({tag, " var0 addr"}, xa_a, ea[31:0]);
        chk({tag, " var0 err"}, {31'd0, xe_a}, {31'd0, ea[32]});
        chk({tag, " var1 addr"}, xa_b, eb[31:0]);
        chk({tag, " var1 err"}, {31'd0, xe_b}, {31'd0, eb[32]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [32:0] e_old, e_new;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all eight registers
        for (int i = 0; i < 8; i++) do_read("R1 reset", 8'(i * 4), 4'hF, 32'd0);

        // R2: write and read back each register
        for (int i = 0; i < 8; i++) do_write(8'(i * 4), 32'hA5000000 | 32'(i * 32'h1111), 4'hF);
        for (int i = 0; i < 8; i++) do_read("R2 readback", 8'(i * 4), 4'hF, mdl[i]);

        // R3: partial writes ignored, partial reads return zero
        do_write(8'h00, 32'hDEADBEEF, 4'h7);
        do_read("R3 partial write", 8'h00, 4'hF, mdl[0]);
        do_read("R3 partial read", 8'h04, 4'h3, 32'd0);

        // R4: unmapped and unaligned offsets
        do_write(8'h20, 32'h12345678, 4'hF);
        do_write(8'h05, 32'h12345678, 4'hF);
        for (int i = 0; i < 8; i++) do_read("R4 no side effect", 8'(i * 4), 4'hF, mdl[i]);
        do_read("R4 unmapped read", 8'h24, 4'hF, 32'd0);
        do_read("R4 unaligned read", 8'h02, 4'hF, 32'd0);

        // R5/R6/R7 directed window edges
        do_write(8'h00, 32'hFFFF_FFF3, 4'hF);
        do_write(8'h04, 32'h1234_5678, 4'hF);
        do_write(8'h08, 32'h8765_4321, 4'hF);
        for (int w = 0; w < 4; w++) begin
            do_xlate("R7 R9 last0", w, wsize(0, w) - 32'd1);
            do_xlate("R7 R9 last1", w, wsize(1, w) - 32'd1);
            do_xlate("R7 R9 end0", w, wsize(0, w));
            do_xlate("R7 R9 end1", w, wsize(1, w));
            do_xlate("R5 R6 R8 zero", w, 32'd0);
        end

        // R10: map write seen only after the edge
        @(negedge clk);
        xl_win = 2'd0; xl_offset = 32'h0000_0100;
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_00A5; reg_be = 4'hF;
        #1;
        e_old = exp_x(0, 0, 32'h100);
        chk("R10 old map var0", xa_a, e_old[31:0]);
        e_old = exp_x(1, 0, 32'h100);
        chk("R10 old map var1", xa_b, e_old[31:0]);
        mdl[0] = 32'h0000_00A5;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        e_new = exp_x(0, 0, 32'h100);
        chk("R10 new map var0", xa_a, e_new[31:0]);
        e_new = exp_x(1, 0, 32'h100);
        chk("R10 new map var1", xa_b, e_new[31:0]);

        // R11: other registers do not touch translation
        for (int i = 3; i < 8; i++) do_write(8'(i * 4), 32'hFFFF_FFFF, 4'hF);
        for (int w = 0; w < 4; w++) do_xlate("R11 side regs", w, 32'h0000_0ABC);

        // Random mix of writes, reads and translations
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                int r;
                logic [7:0] a;
                logic [3:0] be;
                r = int'($urandom % 10);
                if (r < 8) a = 8'(r * 4);
                else if (r == 8) a = 8'h20 + 8'(($urandom % 56) * 4);
                else a = 8'(($urandom % 8) * 4) | 8'(1 + $urandom % 3);
                be = ($urandom % 5 == 0) ? 4'(($urandom % 15)) : 4'hF;
                do_write(a, $urandom, be);
            end else if (op == 1) begin
                int r;
                r = int'($urandom % 8);
                do_read("R2 random read", 8'(r * 4), 4'hF, mdl[r]);
            end else begin
                int w, k;
                logic [31:0] off;
                w = int'($urandom % 4);
                k = int'($urandom % 4);
                off = $urandom;
                if (k == 0) off = off % wsize(0, w);
                else if (k == 1) off = off % wsize(1, w);
                else if (k == 2) off = wsize(int'($urandom % 2), w) + 32'($urandom % 4) - 32'd2;
                do_xlate("R5 R6 R8 R9 random", w, off);
            end
        end

        finish_run();
    end
endmodule